// File: doc/BRIEF.md
# Storage-Key Access Protection Checker

This block decides whether a single memory reference is prohibited by key-controlled protection. For each request it takes the logical address, the type of reference (fetch or store), the storage key of the block that the address falls in, the access key of the requester, the addressing mode and a small set of control bits. It returns a protected flag and a reason code. Key storage, address translation and interrupt delivery belong to the surrounding pipeline.

A fetch and a store are weighed by different rule sets. A fetch is blocked only by key mismatch on a fetch-protected block, with two override paths. A store is first screened against low-address protection and page/access-list protection. After that, a zero access key, the key-9 override and key matching are applied in a fixed order. The verdict is either combinational or registered once, depending on a parameter.

Top module: `key_prot_checker`

## Requirements
- R1: While `rst_n` is low, and at the first sampling point after reset, `prot_o` is 0 and `reason_o` is 0, whatever the request inputs are.
- R2: A fetch is allowed when the access key's upper nibble is zero, when that nibble equals the storage key's upper nibble, or when storage-key bit 3 (fetch-protect) is clear. The access key's lower nibble and storage-key bits 2:0 have no effect.
- R3: A fetch that fails R2 is still allowed when the address is below 2048, `fetch_ovr_i` is set and `private_i` is clear. At address 2048, or with `private_i` set, it stays protected.
- R4: When `store_ovr_i` is set and the storage key's upper nibble is 9, a fetch that fails R2 and R3 is allowed. A store that passes the low-address and page checks is also allowed.
- R5: With `mode64_i`=1 the low-address window is addresses 0–511 and 4096–4607, and nothing else (any higher address bit set puts the address outside). With `mode64_i`=0 the window is 0–511 only.
- R6: Low-address protection is active only when `lowprot_en_i`=1, `guest_i`=0 and `private_i`=0.
- R7: A store is checked in this order: active low-address protection blocks it (reason 2); otherwise `page_prot_i` blocks it (reason 3); otherwise a zero access-key nibble allows it; otherwise the key-9 override allows it; otherwise a nibble mismatch blocks it (reason 1); otherwise it is allowed.
- R8: A fetch is never blocked by low-address protection or by `page_prot_i`.
- R9: Reason encoding: 0 = not protected, 1 = key mismatch, 2 = low-address protection, 3 = page/access-list protection. `prot_o` is 1 exactly when `reason_o` is nonzero.
- R10: With `REG_OUT`=1 (default) the verdict for the inputs present at a rising clock edge appears on the outputs after that edge. With `REG_OUT`=0 the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Logical address of the reference |
| is_store_i | input | 1 | 1 = store, 0 = fetch |
| stor_key_i | input | 8 | Storage key: control nibble in 7:4, fetch-protect in bit 3 |
| acc_key_i | input | 8 | Access key in bits 7:4 |
| mode64_i | input | 1 | 1 = 64-bit addressing mode, 0 = older mode |
| lowprot_en_i | input | 1 | Low-address protection enable |
| fetch_ovr_i | input | 1 | Fetch-protection override enable |
| store_ovr_i | input | 1 | Key-9 storage-protection override enable |
| private_i | input | 1 | Reference is in a private address space |
| page_prot_i | input | 1 | Page or access-list protection applies |
| guest_i | input | 1 | Reference is a guest reference in guest mode |
| prot_o | output | 1 | Reference is prohibited |
| reason_o | output | 2 | Reason code per R9 |

## Verification
The assertions assume every request input is driven to a known value and held steady between rising edges, so that the verdict at an edge belongs to one request. The latency check also assumes reset is not reasserted between two consecutive samples. The bench drives a new request on each falling edge from directed corner vectors and from biased random draws. Those draws concentrate addresses on the window and override boundaries and keys on nibble values 0, 9 and near-matches. It never leaves an input undriven.

// File: rtl/kp_pkg.sv
package kp_pkg;

  localparam int KEY_W = 8;
  localparam int NIB_W = 4;
  localparam int FP_BIT = 3;
  localparam logic [NIB_W-1:0] OVR_KEY = 4'd9;

  typedef enum logic [1:0] {
    RSN_NONE    = 2'd0,
    RSN_KEY     = 2'd1,
    RSN_LOWADDR = 2'd2,
    RSN_PAGE    = 2'd3
  } reason_e;

  typedef struct packed {
    logic    prot;
    reason_e why;
  } verdict_t;

  // control nibble of a key byte
  function automatic logic [NIB_W-1:0] ctl_nib(input logic [KEY_W-1:0] k);
    return k[KEY_W-1 -: NIB_W];
  endfunction

  // access key equals storage control nibble
  function automatic logic nib_match(input logic [KEY_W-1:0] ak,
                                     input logic [KEY_W-1:0] sk);
    return ctl_nib(ak) == ctl_nib(sk);
  endfunction

  function automatic logic key9_ovr(input logic [KEY_W-1:0] sk, input logic en);
    return en && (ctl_nib(sk) == OVR_KEY);
  endfunction

  function automatic verdict_t allow();
    verdict_t v;
    v.prot = 1'b0;
    v.why  = RSN_NONE;
    return v;
  endfunction

  function automatic verdict_t block(input reason_e r);
    verdict_t v;
    v.prot = 1'b1;
    v.why  = r;
    return v;
  endfunction

endpackage

// File: rtl/kp_lowaddr_win.sv
module kp_lowaddr_win #(
  parameter int ADDR_W     = 64,
  parameter int WIN_BYTES  = 512,
  parameter int ALIAS_BASE = 4096
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode64_i,
  output logic              in_win_o
);
  // keep-out mask: every bit except the window offset and the alias bit
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(WIN_BYTES - 1);
  localparam logic [ADDR_W-1:0] ALIAS_BIT = ADDR_W'(ALIAS_BASE);
  localparam logic [ADDR_W-1:0] WIDE_KEEP = ~(OFS_MASK | ALIAS_BIT);
  localparam logic [ADDR_W-1:0] OLD_KEEP  = ~OFS_MASK;

  logic hit_wide;
  logic hit_old;

  assign hit_wide = (addr_i & WIDE_KEEP) == '0;
  assign hit_old  = (addr_i & OLD_KEEP) == '0;
  assign in_win_o = mode64_i ? hit_wide : hit_old;
endmodule

// File: rtl/kp_fetch_eval.sv
module kp_fetch_eval
  import kp_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int FOVR_LIMIT  = 2048
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  stor_key_i,
  input  logic [KEY_W-1:0]  acc_key_i,
  input  logic              fetch_ovr_i,
  input  logic              store_ovr_i,
  input  logic              private_i,
  output verdict_t          verdict_o
);
  logic key_ok;
  logic low_ovr;
  logic k9_ok;

  assign key_ok  = (ctl_nib(acc_key_i) == '0) || nib_match(acc_key_i, stor_key_i)
                   || !stor_key_i[FP_BIT];
  assign low_ovr = fetch_ovr_i && !private_i && (addr_i < ADDR_W'(FOVR_LIMIT));
  assign k9_ok   = key9_ovr(stor_key_i, store_ovr_i);

  always_comb begin
    if (key_ok || low_ovr || k9_ok) verdict_o = allow();
    else                            verdict_o = block(RSN_KEY);
  end
endmodule

// File: rtl/kp_store_eval.sv
module kp_store_eval
  import kp_pkg::*;
(
  input  logic             lap_active_i,
  input  logic             page_prot_i,
  input  logic [KEY_W-1:0] stor_key_i,
  input  logic [KEY_W-1:0] acc_key_i,
  input  logic             store_ovr_i,
  output verdict_t         verdict_o
);
  always_comb begin
    if (lap_active_i)                          verdict_o = block(RSN_LOWADDR);
    else if (page_prot_i)                      verdict_o = block(RSN_PAGE);
    else if (ctl_nib(acc_key_i) == '0)         verdict_o = allow();
    else if (key9_ovr(stor_key_i, store_ovr_i)) verdict_o = allow();
    else if (!nib_match(acc_key_i, stor_key_i)) verdict_o = block(RSN_KEY);
    else                                       verdict_o = allow();
  end
endmodule

// File: rtl/key_prot_checker.sv
module key_prot_checker
  import kp_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int WIN_BYTES  = 512,
  parameter int ALIAS_BASE = 4096,
  parameter int FOVR_LIMIT = 2048,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_store_i,
  input  logic [7:0]        stor_key_i,
  input  logic [7:0]        acc_key_i,
  input  logic              mode64_i,
  input  logic              lowprot_en_i,
  input  logic              fetch_ovr_i,
  input  logic              store_ovr_i,
  input  logic              private_i,
  input  logic              page_prot_i,
  input  logic              guest_i,
  output logic              prot_o,
  output logic [1:0]        reason_o
);
  // named internal events, observed by the bound checker
  logic     win_hit;
  logic     lap_active;
  verdict_t fetch_v;
  verdict_t store_v;
  verdict_t sel_v;
  logic     prot_c;
  logic [1:0] reason_c;
  logic     unused_key_bits;

  assign unused_key_bits = ^{acc_key_i[3:0], stor_key_i[2:0]};

  kp_lowaddr_win #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .ALIAS_BASE(ALIAS_BASE)
  ) win_i (
    .addr_i(addr_i), .mode64_i(mode64_i), .in_win_o(win_hit)
  );

  assign lap_active = win_hit && lowprot_en_i && !guest_i && !private_i;

  kp_fetch_eval #(.ADDR_W(ADDR_W), .FOVR_LIMIT(FOVR_LIMIT)) fetch_i (
    .addr_i(addr_i), .stor_key_i(stor_key_i), .acc_key_i(acc_key_i),
    .fetch_ovr_i(fetch_ovr_i), .store_ovr_i(store_ovr_i),
    .private_i(private_i), .verdict_o(fetch_v)
  );

  kp_store_eval store_i (
    .lap_active_i(lap_active), .page_prot_i(page_prot_i),
    .stor_key_i(stor_key_i), .acc_key_i(acc_key_i),
    .store_ovr_i(store_ovr_i), .verdict_o(store_v)
  );

  assign sel_v    = is_store_i ? store_v : fetch_v;
  assign prot_c   = sel_v.prot;
  assign reason_c = sel_v.why;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prot_o   <= 1'b0;
          reason_o <= 2'd0;
        end else begin
          prot_o   <= prot_c;
          reason_o <= reason_c;
        end
      end
    end else begin : g_comb
      assign prot_o   = prot_c;
      assign reason_o = reason_c;
    end
  endgenerate
endmodule

// File: rtl/kp_prot_chk.sv
module kp_prot_chk #(
  parameter int ADDR_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              is_store_i,
  input logic [7:0]        acc_key_i,
  input logic              mode64_i,
  input logic              page_prot_i,
  input logic              win_hit,
  input logic              lap_active,
  input logic              prot_c,
  input logic [1:0]        reason_c,
  input logic              prot_o,
  input logic [1:0]        reason_o
);
  // R7
  lap_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_store_i && lap_active) |-> (prot_c && reason_c == 2'd2));

  // R7
  page_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_store_i && !lap_active && page_prot_i) |-> (prot_c && reason_c == 2'd3));

  // R8
  fetch_no_lap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_store_i |-> (reason_c == 2'd0 || reason_c == 2'd1));

  // R2
  key0_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_store_i && acc_key_i[7:4] == 4'd0) |-> !prot_c);

  // R5
  old_mode_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode64_i && addr_i >= ADDR_W'(4096) && addr_i < ADDR_W'(4608)) |-> !win_hit);

  // R9
  reason_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_o == (reason_o != 2'd0));

  generate
    if (REG_OUT) begin : g_lat
      // R10
      out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prot_o == $past(prot_c) && reason_o == $past(reason_c)));
    end
  endgenerate
endmodule

bind key_prot_checker kp_prot_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .is_store_i(is_store_i),
  .acc_key_i(acc_key_i), .mode64_i(mode64_i), .page_prot_i(page_prot_i),
  .win_hit(win_hit), .lap_active(lap_active), .prot_c(prot_c),
  .reason_c(reason_c), .prot_o(prot_o), .reason_o(reason_o)
);

// File: tb/key_prot_checker_tb_top.sv
module key_prot_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] addr;
  logic        st, m64, lpe, fov, sov, prv, pgp, gst;
  logic [7:0]  skey, akey;
  logic        prot;
  logic [1:0]  rsn;
  int          n_chk = 0;
  int          n_err = 0;

  always #4 clk = ~clk;

  key_prot_checker dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .is_store_i(st),
    .stor_key_i(skey), .acc_key_i(akey), .mode64_i(m64),
    .lowprot_en_i(lpe), .fetch_ovr_i(fov), .store_ovr_i(sov),
    .private_i(prv), .page_prot_i(pgp), .guest_i(gst),
    .prot_o(prot), .reason_o(rsn)
  );

  // behavioural reference: returns reason code, 0 = allowed
  function automatic int ref_reason();
    int an = akey >> 4;
    int sn = skey >> 4;
    bit fp = (skey & 8'h08) != 0;
    bit win = (addr < 64'd512) || (m64 && addr >= 64'd4096 && addr < 64'd4608);
    bit lap = win && lpe && !gst && !prv;
    bit k9 = sov && sn == 9;
    if (!st) begin
      if (an == 0 || an == sn || !fp) return 0;
      if (fov && !prv && addr < 64'd2048) return 0;
      if (k9) return 0;
      return 1;
    end
    if (lap) return 2;
    if (pgp) return 3;
    if (an == 0) return 0;
    if (k9) return 0;
    if (an != sn) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input int exp_r);
    n_chk++;
    if (rsn != 2'(exp_r) || prot != (exp_r != 0)) begin
      n_err++;
      $display("FAIL %s actual prot=%0d reason=%0d expected prot=%0d reason=%0d",
               tag, prot, rsn, exp_r != 0, exp_r);
    end
  endtask

  task automatic drive(input bit s, input logic [63:0] a, input logic [7:0] sk,
                       input logic [7:0] ak, input bit mm, input bit le,
                       input bit fo, input bit so, input bit pv, input bit pg,
                       input bit gs);
    st = s; addr = a; skey = sk; akey = ak; m64 = mm; lpe = le;
    fov = fo; sov = so; prv = pv; pgp = pg; gst = gs;
  endtask

  // drive at falling edge, sample 2 ns after the following rising edge
  task automatic apply(input string tag, input int exp_r);
    int e;
    @(posedge clk);
    e = ref_reason();
    if (e != exp_r) begin
      n_chk++; n_err++;
      $display("FAIL %s model actual=%0d expected=%0d", tag, e, exp_r);
    end
    #2;
    check(tag, exp_r);
    @(negedge clk);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog all-R actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: protected-looking request during reset
    drive(1, 64'h0, 8'h38, 8'h50, 1, 1, 0, 0, 0, 1, 0);
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", 0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 after release", 0);
    @(negedge clk);

    // R2 fetch rules
    drive(0, 64'h8000, 8'h38, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R2 mismatch fp", 1);
    drive(0, 64'h8000, 8'h38, 8'h3F, 1, 1, 0, 0, 0, 0, 0); apply("R2 match lownib ignored", 0);
    drive(0, 64'h8000, 8'h30, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R2 fp clear", 0);
    drive(0, 64'h8000, 8'h3F, 8'h00, 1, 1, 0, 0, 0, 0, 0); apply("R2 key zero", 0);
    drive(0, 64'h8000, 8'h37, 8'h5F, 1, 1, 0, 0, 0, 0, 0); apply("R2 low bits of skey", 0);
    // R3 fetch override boundary
    drive(0, 64'd2047, 8'h38, 8'h50, 1, 1, 1, 0, 0, 0, 0); apply("R3 below 2048", 0);
    drive(0, 64'd2048, 8'h38, 8'h50, 1, 1, 1, 0, 0, 0, 0); apply("R3 at 2048", 1);
    drive(0, 64'd100, 8'h38, 8'h50, 1, 1, 1, 0, 1, 0, 0); apply("R3 private", 1);
    // R4 key-9 override
    drive(0, 64'h8000, 8'h98, 8'h50, 1, 1, 0, 1, 0, 0, 0); apply("R4 fetch key9", 0);
    drive(1, 64'h8000, 8'h98, 8'h50, 1, 1, 0, 1, 0, 0, 0); apply("R4 store key9", 1 * 0);
    drive(1, 64'h8000, 8'h98, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R4 store no ovr", 1);
    // R5 windows
    drive(1, 64'h1000, 8'h50, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R5 wide alias start", 2);
    drive(1, 64'h11FF, 8'h50, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R5 wide alias end", 2);
    drive(1, 64'h1200, 8'h50, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R5 past alias", 0);
    drive(1, 64'h0200, 8'h50, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R5 at 512", 0);
    drive(1, 64'h1_0000_0000, 8'h50, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R5 high bit", 0);
    drive(1, 64'h1000, 8'h50, 8'h50, 0, 1, 0, 0, 0, 0, 0); apply("R5 old mode alias", 0);
    drive(1, 64'h01FF, 8'h50, 8'h50, 0, 1, 0, 0, 0, 0, 0); apply("R5 old mode 511", 2);
    // R6 enables
    drive(1, 64'h0, 8'h50, 8'h50, 1, 0, 0, 0, 0, 0, 0); apply("R6 disabled", 0);
    drive(1, 64'h0, 8'h50, 8'h50, 1, 1, 0, 0, 0, 0, 1); apply("R6 guest", 0);
    drive(1, 64'h0, 8'h50, 8'h50, 1, 1, 0, 0, 1, 0, 0); apply("R6 private", 0);
    // R7 store priority
    drive(1, 64'h0, 8'h50, 8'h00, 1, 1, 0, 0, 0, 1, 0); apply("R7 lap over page key0", 2);
    drive(1, 64'h8000, 8'h50, 8'h00, 1, 1, 0, 0, 0, 1, 0); apply("R7 page over key0", 3);
    drive(1, 64'h8000, 8'h50, 8'h00, 1, 1, 0, 0, 0, 0, 0); apply("R7 key0 allows", 0);
    drive(1, 64'h8000, 8'h98, 8'h50, 1, 1, 0, 1, 0, 1, 0); apply("R7 page over key9", 3);
    drive(1, 64'h8000, 8'h60, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R7 mismatch", 1);
    drive(1, 64'h8000, 8'h58, 8'h50, 1, 1, 0, 0, 0, 0, 0); apply("R7 match", 0);
    // R8 fetch ignores lap and page
    drive(0, 64'h0, 8'h50, 8'h50, 1, 1, 0, 0, 0, 1, 0); apply("R8 fetch in window page", 0);

    // R9 random, compared every clock against the model
    for (int i = 0; i < 600; i++) begin
      int pick = int'($urandom_range(0, 7));
      logic [63:0] a;
      case (pick)
        0: a = 64'($urandom_range(0, 700));
        1: a = 64'($urandom_range(4000, 4700));
        2: a = 64'($urandom_range(2040, 2056));
        3: a = {32'($urandom_range(0, 1)), 32'($urandom_range(0, 5000))};
        default: a = {$urandom, $urandom};
      endcase
      drive(1'($urandom), a,
            {4'($urandom_range(8, 10)), 4'($urandom)},
            {4'($urandom_range(0, 2) == 0 ? 0 : $urandom_range(8, 10)), 4'($urandom)},
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 3) == 0));
      apply("R9 random", ref_reason());
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule